// File: doc/BRIEF.md
# Digital I/O Port with Per-Pin Alternate-Function Takeover

This block is a parameterized digital I/O port, eight pins wide by default. Each pin has a direction bit and an output-value bit held in two port-wide registers, plus a two-stage input synchronizer that feeds a readable pin-state view. Software reaches these through strobed accesses. There is one write strobe and one read strobe for each register, and one read strobe for the synchronized pin state. All of them share a single data bus in each direction.

Peripheral logic can take control of any pin, one function at a time. Every pin accepts four enable/value pairs. These replace the register-derived pull-up request, output enable, output data and input enable. Each pair acts on its own, so a peripheral can drive a pin's data while software still owns its direction. A port-wide pull-up kill input turns off every pull-up that is not overridden. A sleep input closes the digital input path of every pin whose input-enable is not overridden, so a floating pad cannot disturb the sampled state.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is low, and on release, the direction and output-value registers and both synchronizer stages hold 0. With no override active, every pin therefore reports pad_oe=0 and pad_pu=0, and a pin-state read returns 0 whatever the pad level.
- R2: On a rising clock edge with wr_dir high, the direction register takes wdata. A later read with rd_dir returns that value.
- R3: On a rising clock edge with wr_out high, the output-value register takes wdata. A later read with rd_out returns that value.
- R4: For each pin, pad_oe equals ovr_dir_val when ovr_dir_en is 1, and otherwise the pin's direction bit (1 = output).
- R5: For each pin, pad_do equals ovr_out_val when ovr_out_en is 1, and otherwise the pin's output-value bit.
- R6: When ovr_pu_en is 0, pad_pu of a pin is 1 exactly when its direction bit is 0, its output-value bit is 1 and pullup_dis is 0.
- R7: When ovr_pu_en is 1, pad_pu equals ovr_pu_val, including while pullup_dis is 1.
- R8: A pin's input is enabled by ovr_ie_val when ovr_ie_en is 1, and otherwise when sleep is 0. A disabled input presents 0 to the synchronizer.
- R9: A pin-state read returns the gated pad level sampled two rising edges earlier. A change made before edge k is seen on rdata after edge k+1 and not after edge k alone.
- R10: rdata is the bitwise OR of the direction register (rd_dir), the output-value register (rd_out) and the synchronized pin state (rd_pin), each included only when its strobe is high. With no read strobe, rdata is 0.
- R11: Reads of the direction and output-value registers return the stored bits and are never affected by any override pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Load direction register from wdata |
| rd_dir | input | 1 | Place direction register on rdata |
| wr_out | input | 1 | Load output-value register from wdata |
| rd_out | input | 1 | Place output-value register on rdata |
| rd_pin | input | 1 | Place synchronized pin state on rdata |
| wdata | input | W | Write data |
| rdata | output | W | Read data |
| pullup_dis | input | 1 | Port-wide pull-up kill |
| sleep | input | 1 | Closes non-overridden input paths |
| pad_in | input | W | Raw pad input levels |
| ovr_pu_en | input | W | Pull-up override enable, per pin |
| ovr_pu_val | input | W | Pull-up override value, per pin |
| ovr_dir_en | input | W | Output-enable override enable, per pin |
| ovr_dir_val | input | W | Output-enable override value, per pin |
| ovr_out_en | input | W | Output-data override enable, per pin |
| ovr_out_val | input | W | Output-data override value, per pin |
| ovr_ie_en | input | W | Input-enable override enable, per pin |
| ovr_ie_val | input | W | Input-enable override value, per pin |
| pad_oe | output | W | Pad output enable |
| pad_do | output | W | Pad output data |
| pad_pu | output | W | Pad pull-up request |

## Verification
The synchronizer properties assume that the sleep input and the input-enable override have been steady across the two edges being compared. They therefore check latency only when sleep and every ovr_ie_en bit were low on both of the previous edges, and they check blanking only when sleep was high and no input-enable override was set. The register-load properties assume that the write strobes are sampled cleanly on the edge. The bench changes every input only at the falling edge, and it changes sleep and the override enables freely, relying on these guards to skip the windows in which the assumptions do not hold. The pad levels are treated as already settled at the port, so metastability is outside what is checked.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    // one enable/value pair supplied by a peripheral for a single pin
    typedef struct packed {
        logic en;
        logic val;
    } ovr_pair_t;

    // resolved per-pin controls after override selection
    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
        logic ie;
    } pin_drive_t;

    localparam int unsigned DEFAULT_W      = 8;
    localparam int unsigned DEFAULT_STAGES = 2;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_out,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] outv;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_dir) st_d.dir  = wdata;
        if (wr_out) st_d.outv = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;
    assign out_q = st_q.outv;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb sh_d[s] = d;
            end else begin : g_next
                always_comb sh_d[s] = sh_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[LAST];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ovr_pkg::*;
(
    input  logic       dir_bit,
    input  logic       out_bit,
    input  logic       pu_dis,
    input  logic       sleep,
    input  ovr_pair_t  pu_ovr,
    input  ovr_pair_t  dir_ovr,
    input  ovr_pair_t  out_ovr,
    input  ovr_pair_t  ie_ovr,
    output pin_drive_t drv
);

    logic base_pu;
    logic base_ie;

    always_comb begin
        base_pu  = ~dir_bit & out_bit & ~pu_dis;
        base_ie  = ~sleep;
        drv.oe   = dir_ovr.en ? dir_ovr.val : dir_bit;
        drv.dout = out_ovr.en ? out_ovr.val : out_bit;
        drv.pu   = pu_ovr.en  ? pu_ovr.val  : base_pu;
        drv.ie   = ie_ovr.en  ? ie_ovr.val  : base_ie;
    end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned W      = DEFAULT_W,
    parameter int unsigned STAGES = DEFAULT_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         rd_dir,
    input  logic         wr_out,
    input  logic         rd_out,
    input  logic         rd_pin,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         pullup_dis,
    input  logic         sleep,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] ovr_pu_en,
    input  logic [W-1:0] ovr_pu_val,
    input  logic [W-1:0] ovr_dir_en,
    input  logic [W-1:0] ovr_dir_val,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_val,
    input  logic [W-1:0] ovr_ie_en,
    input  logic [W-1:0] ovr_ie_val,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_do,
    output logic [W-1:0] pad_pu
);

    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] pin_q;
    logic [W-1:0] sync_in;
    pin_drive_t   drv [W];

    gpio_port_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_dir (wr_dir),
        .wr_out (wr_out),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            ovr_pair_t pu_p, dir_p, out_p, ie_p;
            assign pu_p  = {ovr_pu_en[i],  ovr_pu_val[i]};
            assign dir_p = {ovr_dir_en[i], ovr_dir_val[i]};
            assign out_p = {ovr_out_en[i], ovr_out_val[i]};
            assign ie_p  = {ovr_ie_en[i],  ovr_ie_val[i]};

            gpio_pin_mux u_mux (
                .dir_bit (dir_q[i]),
                .out_bit (out_q[i]),
                .pu_dis  (pullup_dis),
                .sleep   (sleep),
                .pu_ovr  (pu_p),
                .dir_ovr (dir_p),
                .out_ovr (out_p),
                .ie_ovr  (ie_p),
                .drv     (drv[i])
            );

            assign pad_oe[i]  = drv[i].oe;
            assign pad_do[i]  = drv[i].dout;
            assign pad_pu[i]  = drv[i].pu;
            // a closed input path feeds 0 so a floating pad is not sampled
            assign sync_in[i] = pad_in[i] & drv[i].ie;
        end
    endgenerate

    gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (pin_q)
    );

    always_comb begin
        rdata = '0;
        if (rd_dir) rdata = rdata | dir_q;
        if (rd_out) rdata = rdata | out_q;
        if (rd_pin) rdata = rdata | pin_q;
    end

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_dir,
    input logic         wr_out,
    input logic         rd_dir,
    input logic         rd_out,
    input logic         rd_pin,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic         pullup_dis,
    input logic         sleep,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] ovr_pu_en,
    input logic [W-1:0] ovr_dir_en,
    input logic [W-1:0] ovr_dir_val,
    input logic [W-1:0] ovr_out_en,
    input logic [W-1:0] ovr_out_val,
    input logic [W-1:0] ovr_ie_en,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_do,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] out_q,
    input logic [W-1:0] pin_q
);

    // edges seen since reset release, saturating at 2
    logic [1:0] up_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            up_cnt <= 2'd0;
        else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && out_q == '0 && pin_q == '0));

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(wdata));

    // R3
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> out_q == $past(wdata));

    // R4
    oe_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ ovr_dir_val) & ovr_dir_en) == '0) &&
        (((pad_oe ^ dir_q) & ~ovr_dir_en) == '0));

    // R5
    do_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_do ^ ovr_out_val) & ovr_out_en) == '0) &&
        (((pad_do ^ out_q) & ~ovr_out_en) == '0));

    // R6
    pu_output_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~ovr_pu_en & (dir_q | ~out_q)) == '0);

    // R7
    pu_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_dis |-> (pad_pu & ~ovr_pu_en) == '0);

    // R8
    sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2 && $past(sleep) && $past(sleep, 2) &&
         $past(ovr_ie_en) == '0 && $past(ovr_ie_en, 2) == '0) |-> pin_q == '0);

    // R9
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2 && !$past(sleep) && !$past(sleep, 2) &&
         $past(ovr_ie_en) == '0 && $past(ovr_ie_en, 2) == '0)
        |-> pin_q == $past(pad_in, 2));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_dir || rd_out || rd_pin) |-> rdata == '0);

    // R11
    rd_dir_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dir && !rd_out && !rd_pin) |-> rdata == dir_q);

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_dir      (wr_dir),
    .wr_out      (wr_out),
    .rd_dir      (rd_dir),
    .rd_out      (rd_out),
    .rd_pin      (rd_pin),
    .wdata       (wdata),
    .rdata       (rdata),
    .pullup_dis  (pullup_dis),
    .sleep       (sleep),
    .pad_in      (pad_in),
    .ovr_pu_en   (ovr_pu_en),
    .ovr_dir_en  (ovr_dir_en),
    .ovr_dir_val (ovr_dir_val),
    .ovr_out_en  (ovr_out_en),
    .ovr_out_val (ovr_out_val),
    .ovr_ie_en   (ovr_ie_en),
    .pad_oe      (pad_oe),
    .pad_do      (pad_do),
    .pad_pu      (pad_pu),
    .dir_q       (dir_q),
    .out_q       (out_q),
    .pin_q       (pin_q)
);

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_dir = 0, rd_dir = 0, wr_out = 0, rd_out = 0, rd_pin = 0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         pullup_dis = 0, sleep = 0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] ovr_pu_en = '0, ovr_pu_val = '0;
    logic [W-1:0] ovr_dir_en = '0, ovr_dir_val = '0;
    logic [W-1:0] ovr_out_en = '0, ovr_out_val = '0;
    logic [W-1:0] ovr_ie_en = '0, ovr_ie_val = '0;
    logic [W-1:0] pad_oe, pad_do, pad_pu;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ovr_port u_gpio_ovr_port (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .rd_dir(rd_dir), .wr_out(wr_out), .rd_out(rd_out),
        .rd_pin(rd_pin), .wdata(wdata), .rdata(rdata),
        .pullup_dis(pullup_dis), .sleep(sleep), .pad_in(pad_in),
        .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
        .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
        .ovr_out_en(ovr_out_en), .ovr_out_val(ovr_out_val),
        .ovr_ie_en(ovr_ie_en), .ovr_ie_val(ovr_ie_val),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_out = '0;
    logic [W-1:0] m_hist [$];
    logic [31:0]  lfsr = 32'h1234_5678;

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_pu();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (ovr_pu_en[i]) r[i] = ovr_pu_val[i];
            else r[i] = (m_dir[i] == 1'b0) && (m_out[i] == 1'b1) && !pullup_dis;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_gate();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (ovr_ie_en[i]) r[i] = ovr_ie_val[i] & pad_in[i];
            else r[i] = sleep ? 1'b0 : pad_in[i];
        end
        return r;
    endfunction

    // compare every output, then advance one clock and update the reference
    task automatic step();
        logic [W-1:0] e;
        string lbl;
        #(CLK_PERIOD/4);
        for (int i = 0; i < W; i++) e[i] = ovr_dir_en[i] ? ovr_dir_val[i] : m_dir[i];
        check("R4 oe", pad_oe, e);
        for (int i = 0; i < W; i++) e[i] = ovr_out_en[i] ? ovr_out_val[i] : m_out[i];
        check("R5 dout", pad_do, e);
        check("R6 R7 pullup", pad_pu, exp_pu());
        e = '0;
        lbl = "R10 rdata";
        if (rd_dir) begin e = e | m_dir;      lbl = {lbl, " R2 R11"}; end
        if (rd_out) begin e = e | m_out;      lbl = {lbl, " R3 R11"}; end
        if (rd_pin) begin e = e | m_hist[0];  lbl = {lbl, " R8 R9"};  end
        check(lbl, rdata, e);
        @(posedge clk);
        m_hist.push_back(exp_gate());
        void'(m_hist.pop_front());
        if (wr_dir) m_dir = wdata;
        if (wr_out) m_out = wdata;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        {wr_dir, rd_dir, wr_out, rd_out, rd_pin} = '0;
        {ovr_pu_en, ovr_dir_en, ovr_out_en, ovr_ie_en} = '0;
        pullup_dis = 0;
        sleep = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_hist.push_back('0);
        m_hist.push_back('0);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: outputs while in reset and right after release
        #(CLK_PERIOD/4);
        check("R1 oe in reset", pad_oe, '0);
        check("R1 pu in reset", pad_pu, '0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_pin = 1;
        #(CLK_PERIOD/4);
        check("R1 pin after reset", rdata, '0);
        rd_pin = 0;
        rd_dir = 1;
        #1;
        check("R1 dir after reset", rdata, '0);
        rd_dir = 0;
        @(negedge clk);

        // R2 R3: register loads and readback
        wr_dir = 1; wdata = 8'h0F; step();
        wr_dir = 0; wr_out = 1; wdata = 8'hA5; step();
        wr_out = 0; rd_dir = 1; #1;
        check("R2 dir readback", rdata, 8'h0F);
        step();
        rd_dir = 0; rd_out = 1; #1;
        check("R3 out readback", rdata, 8'hA5);
        // R6: pull-up on input pins whose output bit is 1 (0xA5 & ~0x0F)
        check("R6 pullup base", pad_pu, 8'hA0);
        step();

        // R11: overrides do not change register reads
        ovr_dir_en = 8'hFF; ovr_dir_val = 8'hF0;
        ovr_out_en = 8'hFF; ovr_out_val = 8'h3C;
        rd_out = 0; rd_dir = 1; #1;
        check("R11 dir read under override", rdata, 8'h0F);
        check("R4 oe override", pad_oe, 8'hF0);
        rd_dir = 0; rd_out = 1; #1;
        check("R11 out read under override", rdata, 8'hA5);
        check("R5 dout override", pad_do, 8'h3C);
        step();
        idle_inputs();

        // R7: pull-up kill, with one pin forced by override
        pullup_dis = 1; #1;
        check("R7 kill", pad_pu, 8'h00);
        ovr_pu_en = 8'h01; ovr_pu_val = 8'h01; #1;
        check("R7 forced under kill", pad_pu, 8'h01);
        step();
        idle_inputs();

        // R9: two-edge input latency
        pad_in = 8'h00; step(); step(); step();
        rd_pin = 1;
        pad_in = 8'h5A;
        step();
        #1; check("R9 after one edge", rdata, 8'h00);
        step();
        #1; check("R9 after two edges", rdata, 8'h5A);
        step();

        // R8: sleep blanks the input except where the override keeps it open
        sleep = 1; ovr_ie_en = 8'h03; ovr_ie_val = 8'h02; pad_in = 8'hFF;
        step(); step();
        #1; check("R8 sleep gating", rdata, 8'h02);
        step();
        idle_inputs();
        step(); step();

        // randomized phase with the reference compared every cycle
        for (int n = 0; n < 400; n++) begin
            lfsr = next_rand(lfsr);
            {wr_dir, rd_dir, wr_out, rd_out, rd_pin, pullup_dis, sleep} = lfsr[6:0];
            wdata = lfsr[15:8];
            pad_in = lfsr[23:16];
            lfsr = next_rand(lfsr);
            ovr_pu_en  = lfsr[7:0] & lfsr[15:8];
            ovr_pu_val = lfsr[23:16];
            ovr_dir_en = lfsr[31:24] & lfsr[7:0];
            lfsr = next_rand(lfsr);
            ovr_dir_val = lfsr[7:0];
            ovr_out_en  = lfsr[15:8] & lfsr[23:16];
            ovr_out_val = lfsr[31:24];
            lfsr = next_rand(lfsr);
            ovr_ie_en  = lfsr[7:0] & lfsr[15:8];
            ovr_ie_val = lfsr[23:16];
            step();
        end

        idle_inputs();
        step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule